// File: doc/BRIEF.md
# Power-Up Sequencer and Fault Supervisor

This block is the digital start-up and protection controller of a synchronous buck converter. It counts switching-cycle ticks from the moment shutdown is released. From that count it derives three things: a stepped current-limit code for the soft-start DAC, a delayed release of the power-good reset output, and a delayed arming of output-undervoltage protection. The counter is held at zero while shutdown is asserted, so every release starts the sequence again from the beginning.

The block also watches comparator flags. An output overvoltage or an undervoltage on either input supply latches the converter off and keeps the synchronous rectifier on, which pulls the output toward ground. An armed output undervoltage latches the converter off and forces no gate on. Over-temperature turns the converter off only while its flag is high, because the comparator supplies the hysteresis. A low reading on either regulator rail pulls reset low. The block has no data path, so every pin is a plain level signal. The tick input is a one-clock pulse per switching cycle.

Top module: `pwr_seq_supervisor`

## Requirements
- R1: While `shdn_n` is low, or `rst_n` is low, `conv_en`, `force_ls`, `reset_n_out` and `fault_latched` are 0 and `ilim_code` is 0. Ticks received during shutdown are not counted.
- R2: Let k be the number of clock edges with `cyc_tick` high since `shdn_n` went high. Then `ilim_code` equals min(floor(k / STEP_CYC), 4). The codes 0,1,2,3,4 mean 0, 25, 50, 75 and 100 percent current limit. At the default STEP_CYC of 128, code 4 is reached after 512 cycles.
- R3: `reset_n_out` stays 0 while k < RST_HOLD_CYC (default 32768). It is 1 once k >= RST_HOLD_CYC, provided no rail is low.
- R4: `reset_n_out` is 0 in the same cycle that any bit of `rail_low` is 1. It returns to 1 when all bits clear, provided R3's condition holds.
- R5: `uv_flag` sampled at a clock edge where k < UV_ARM_CYC (default 5000) has no effect: `fault_latched` stays 0 and `conv_en` stays 1.
- R6: `uv_flag` sampled at an edge where k >= UV_ARM_CYC sets the latch. From the next cycle `fault_latched` = 1, `conv_en` = 0 and `force_ls` = 0.
- R7: `ov_flag` sampled high at an edge while running sets the latch. From the next cycle `fault_latched` = 1, `conv_en` = 0 and `force_ls` = 1.
- R8: Any bit of `vin_uv` sampled high gives exactly the R7 response.
- R9: While `ot_flag` is 1, `conv_en` is 0 in the same cycle and no fault is latched. `conv_en` returns to 1 when the flag clears.
- R10: A latched fault persists after its flag clears. Only shutdown clears it. After release, `fault_latched` is 0 and the sequence restarts from k = 0.
- R11: The counter saturates. `ilim_code` holds at 4 and `reset_n_out` stays released however many further ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One-clock pulse per switching cycle |
| shdn_n | input | 1 | Low = shutdown, high = run |
| ov_flag | input | 1 | Output overvoltage comparator |
| uv_flag | input | 1 | Output undervoltage comparator |
| vin_uv | input | NUM_SUPPLIES | Input supply undervoltage comparators |
| ot_flag | input | 1 | Over-temperature comparator (with hysteresis) |
| rail_low | input | NUM_RAILS | Regulator output below power-good level |
| ilim_code | output | 3 | Soft-start current-limit step, 0..4 |
| reset_n_out | output | 1 | Power-good reset, active low |
| conv_en | output | 1 | Converter switching enable |
| force_ls | output | 1 | Hold synchronous rectifier on |
| fault_latched | output | 1 | A latch-off fault is held |

## Verification
The undervoltage arming edge is the hardest point to reach from the ports. A flag must arrive exactly one tick before the arming count and again exactly at it, and the outcome shows only in the following cycle. The bench builds its configuration from small cycle thresholds. It tracks the tick count itself while sweeping continuous and gapped tick patterns. It places the undervoltage pulse at the count just below the threshold and then at the threshold, and checks that only the second pulse latches.

// File: rtl/pws_pkg.sv
package pws_pkg;
  localparam int ILIM_W = 3;
  localparam logic [ILIM_W-1:0] ILIM_FULL = 3'd4;
  typedef logic [ILIM_W-1:0] ilim_code_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/pws_cycle_timer.sv
module pws_cycle_timer
  import pws_pkg::*;
#(
  parameter int STEP_CYC     = 128,
  parameter int RST_HOLD_CYC = 32768,
  parameter int UV_ARM_CYC   = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       tick_i,
  output ilim_code_t code_o,
  output logic       hold_done_o,
  output logic       uv_armed_o
);
  localparam int LIMIT = max3(4 * STEP_CYC, RST_HOLD_CYC, UV_ARM_CYC);
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] quo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   cnt_q <= '0;
    else if (!run_i)                              cnt_q <= '0;
    else if (tick_i && (cnt_q != CW'(LIMIT)))     cnt_q <= cnt_q + 1'b1;
  end

  generate
    if ((STEP_CYC & (STEP_CYC - 1)) == 0) begin : g_shift
      assign quo = cnt_q >> $clog2(STEP_CYC);
    end else begin : g_div
      assign quo = cnt_q / CW'(STEP_CYC);
    end
  endgenerate

  always_comb begin
    if (!run_i)                 code_o = '0;
    else if (quo >= CW'(4))     code_o = ILIM_FULL;
    else                        code_o = ilim_code_t'(quo);
  end

  assign hold_done_o = run_i && (cnt_q >= CW'(RST_HOLD_CYC));
  assign uv_armed_o  = run_i && (cnt_q >= CW'(UV_ARM_CYC));

  // R2
  code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> (!run_i || code_o == $past(code_o) || code_o == $past(code_o) + 3'd1));
  // R2
  code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_i) |=> (!run_i || $stable(code_o)));
  // R11
  code_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_o <= ILIM_FULL);
  // R11
  hold_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && hold_done_o) |=> (!run_i || hold_done_o));
endmodule

// File: rtl/pws_fault_sup.sv
module pws_fault_sup #(
  parameter int NUM_SUPPLIES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_i,
  input  logic                    uv_armed_i,
  input  logic                    ov_i,
  input  logic                    uv_i,
  input  logic [NUM_SUPPLIES-1:0] vin_uv_i,
  input  logic                    ot_i,
  output logic                    conv_en_o,
  output logic                    force_ls_o,
  output logic                    latched_o
);
  logic hard_q;
  logic soft_q;
  logic hard_trip;

  assign hard_trip = ov_i || (|vin_uv_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hard_q <= 1'b0;
      soft_q <= 1'b0;
    end else if (!run_i) begin
      hard_q <= 1'b0;
      soft_q <= 1'b0;
    end else begin
      if (hard_trip)           hard_q <= 1'b1;
      if (uv_i && uv_armed_i)  soft_q <= 1'b1;
    end
  end

  assign latched_o  = run_i && (hard_q || soft_q);
  assign force_ls_o = run_i && hard_q;
  assign conv_en_o  = run_i && !hard_q && !soft_q && !ot_i;

  // R7 R8
  hard_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && hard_trip) |=> (!run_i || (force_ls_o && latched_o && !conv_en_o)));
  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && latched_o) |=> (!run_i || latched_o));
  // R5
  uv_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !uv_armed_i && !latched_o && !hard_trip) |=> (!run_i || !latched_o));
  // R6
  uv_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && uv_i && uv_armed_i) |=> (!run_i || (latched_o && !conv_en_o)));
endmodule

// File: rtl/pwr_seq_supervisor.sv
module pwr_seq_supervisor
  import pws_pkg::*;
#(
  parameter int STEP_CYC     = 128,
  parameter int RST_HOLD_CYC = 32768,
  parameter int UV_ARM_CYC   = 5000,
  parameter int NUM_SUPPLIES = 2,
  parameter int NUM_RAILS    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cyc_tick,
  input  logic                    shdn_n,
  input  logic                    ov_flag,
  input  logic                    uv_flag,
  input  logic [NUM_SUPPLIES-1:0] vin_uv,
  input  logic                    ot_flag,
  input  logic [NUM_RAILS-1:0]    rail_low,
  output logic [2:0]              ilim_code,
  output logic                    reset_n_out,
  output logic                    conv_en,
  output logic                    force_ls,
  output logic                    fault_latched
);
  logic       run;
  logic       hold_done;
  logic       uv_armed;
  ilim_code_t code;

  assign run = shdn_n && rst_n;

  pws_cycle_timer #(
    .STEP_CYC    (STEP_CYC),
    .RST_HOLD_CYC(RST_HOLD_CYC),
    .UV_ARM_CYC  (UV_ARM_CYC)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .tick_i     (cyc_tick),
    .code_o     (code),
    .hold_done_o(hold_done),
    .uv_armed_o (uv_armed)
  );

  pws_fault_sup #(
    .NUM_SUPPLIES(NUM_SUPPLIES)
  ) u_sup (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .uv_armed_i(uv_armed),
    .ov_i      (ov_flag),
    .uv_i      (uv_flag),
    .vin_uv_i  (vin_uv),
    .ot_i      (ot_flag),
    .conv_en_o (conv_en),
    .force_ls_o(force_ls),
    .latched_o (fault_latched)
  );

  assign ilim_code   = code;
  assign reset_n_out = hold_done && !(|rail_low);

  // R1
  shdn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |-> (!conv_en && !force_ls && !reset_n_out && !fault_latched && ilim_code == 3'd0));
  // R9
  ot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ot_flag |-> !conv_en);
  // R4
  rail_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rail_low) |-> !reset_n_out);
endmodule

// File: tb/pwr_seq_supervisor_test.sv
module pwr_seq_supervisor_test;
  localparam int STEP = 4;
  localparam int HOLD = 40;
  localparam int ARM  = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_tick = 1'b0;
  logic       shdn_n = 1'b0;
  logic       ov_flag = 1'b0;
  logic       uv_flag = 1'b0;
  logic [1:0] vin_uv = 2'b00;
  logic       ot_flag = 1'b0;
  logic [1:0] rail_low = 2'b00;
  logic [2:0] ilim_code;
  logic       reset_n_out, conv_en, force_ls, fault_latched;

  int n_chk = 0;
  int n_fail = 0;
  int k = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_seq_supervisor #(
    .STEP_CYC(STEP), .RST_HOLD_CYC(HOLD), .UV_ARM_CYC(ARM),
    .NUM_SUPPLIES(2), .NUM_RAILS(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .shdn_n(shdn_n),
    .ov_flag(ov_flag), .uv_flag(uv_flag), .vin_uv(vin_uv), .ot_flag(ot_flag),
    .rail_low(rail_low), .ilim_code(ilim_code), .reset_n_out(reset_n_out),
    .conv_en(conv_en), .force_ls(force_ls), .fault_latched(fault_latched)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input int n);
    return (n / STEP > 4) ? 4 : n / STEP;
  endfunction

  task automatic quiet(input string tag);
    chk({tag, " conv_en"}, conv_en, 0);
    chk({tag, " force_ls"}, force_ls, 0);
    chk({tag, " reset_n_out"}, reset_n_out, 0);
    chk({tag, " fault_latched"}, fault_latched, 0);
    chk({tag, " ilim_code"}, ilim_code, 0);
  endtask

  // restart: shutdown for one edge, then release; returns at negedge with k = 0
  task automatic restart();
    @(negedge clk); shdn_n = 1'b0;
    @(negedge clk); shdn_n = 1'b1; k = 0;
  endtask

  // advance with tick held high until k reaches target
  task automatic advance(input int target);
    while (k < target) begin
      @(negedge clk); k++;
    end
  endtask

  initial begin
    #1;
    quiet("R1 reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc_tick = 1'b1;
    repeat (5) @(negedge clk);
    #1 quiet("R1 shutdown");

    // continuous ticks: soft-start, reset release, saturation
    restart();
    cyc_tick = 1'b1;
    for (int i = 0; i <= 60; i++) begin
      #1;
      chk((i >= 4 * STEP) ? "R11 ilim_code" : "R2 ilim_code", ilim_code, exp_code(i));
      chk((i > HOLD) ? "R11 reset_n_out" : "R3 reset_n_out", reset_n_out, (i >= HOLD) ? 1 : 0);
      chk("R2 conv_en", conv_en, 1);
      @(negedge clk);
    end

    // gapped ticks: one in three cycles
    restart();
    begin
      int n = 0;
      for (int i = 0; i < 150; i++) begin
        #1;
        chk("R2 gapped ilim_code", ilim_code, exp_code(n));
        chk("R3 gapped reset_n_out", reset_n_out, (n >= HOLD) ? 1 : 0);
        cyc_tick = (i % 3 == 0);
        if (cyc_tick) n++;
        @(negedge clk);
      end
    end
    cyc_tick = 1'b1;

    // rails pull reset low immediately
    for (int r = 0; r < 2; r++) begin
      rail_low = 2'b01 << r;
      #1 chk("R4 rail low", reset_n_out, 0);
      @(negedge clk); rail_low = 2'b00;
      #1 chk("R4 rail clear", reset_n_out, 1);
      @(negedge clk);
    end

    // output undervoltage before and at arming
    restart();
    advance(10);
    uv_flag = 1'b1;
    advance(13);
    uv_flag = 1'b0;
    #1 chk("R5 early uv latched", fault_latched, 0);
    chk("R5 early uv conv_en", conv_en, 1);
    advance(ARM - 1);
    uv_flag = 1'b1;
    advance(ARM);
    uv_flag = 1'b0;
    #1 chk("R5 uv one below arm", fault_latched, 0);
    chk("R5 uv one below arm conv_en", conv_en, 1);
    uv_flag = 1'b1;
    advance(ARM + 1);
    uv_flag = 1'b0;
    #1 chk("R6 uv latched", fault_latched, 1);
    chk("R6 uv conv_en", conv_en, 0);
    chk("R6 uv force_ls", force_ls, 0);
    advance(ARM + 6);
    #1 chk("R10 uv held", fault_latched, 1);

    // overvoltage latch, hold, clear by shutdown
    restart();
    advance(3);
    ov_flag = 1'b1;
    advance(4);
    ov_flag = 1'b0;
    #1 chk("R7 ov latched", fault_latched, 1);
    chk("R7 ov force_ls", force_ls, 1);
    chk("R7 ov conv_en", conv_en, 0);
    advance(12);
    #1 chk("R10 ov held", force_ls, 1);
    @(negedge clk); shdn_n = 1'b0;
    #1 quiet("R1 shutdown after fault");
    @(negedge clk); shdn_n = 1'b1; k = 0;
    #1 chk("R10 cleared latch", fault_latched, 0);
    chk("R10 cleared conv_en", conv_en, 1);
    chk("R10 restart ilim_code", ilim_code, 0);
    advance(STEP);
    #1 chk("R10 restart count", ilim_code, 1);

    // input supply undervoltage, each supply
    for (int s = 0; s < 2; s++) begin
      restart();
      advance(2);
      vin_uv = 2'b01 << s;
      advance(3);
      vin_uv = 2'b00;
      #1 chk("R8 vin latched", fault_latched, 1);
      chk("R8 vin force_ls", force_ls, 1);
      chk("R8 vin conv_en", conv_en, 0);
    end

    // over-temperature follows flag
    restart();
    advance(5);
    ot_flag = 1'b1;
    #1 chk("R9 ot conv_en", conv_en, 0);
    advance(8);
    #1 chk("R9 ot no latch", fault_latched, 0);
    ot_flag = 1'b0;
    #1 chk("R9 ot cleared", conv_en, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule